// File: doc/BRIEF.md
# Serial Converter Interface Controller

This block is the digital front end of a 12-bit multichannel converter that is read and commanded over a slow serial link. It runs on a system clock and treats the chip select, the I/O clock and the serial data input as plain asynchronous pins. It synchronises them and detects their edges. A 4-bit command is taken from the first four I/O clocks of each cycle. The block drives a serial data output with its own output enable and an end-of-conversion flag. It also steers the input multiplexer, opens and closes the sample window, and starts the conversion engine.

Chip select must stay steady for a debounce interval before the block acts on it. A cycle can be broken off by raising chip select. A new cycle that starts while a conversion is still running aborts that conversion. Power-down comes in two forms. The software form is entered by command and is left only by a real channel address. The automatic form drops the analog bias after every conversion and restores it when chip select becomes active again. The block leaves reset in software power-down. A behavioural engine inside the block times each conversion and captures the analog word when the conversion ends.

Top module: `sadc_ctrl`

## Requirements
- R1: After reset the output enable is low, end-of-conversion is high, the sample window is closed, the channel select is 0, the analog bias is off (software power-down) and the result buffer reads as zero.
- R2: The output enable follows the synchronised chip select (active low) with no debounce: it drops within 4 system clocks after chip select rises and rises within 4 after it falls.
- R3: A chip-select low pulse shorter than the debounce interval does not start a cycle, and I/O clock edges while chip select is not debounced active change no state: no conversion starts and the channel select keeps its value.
- R4: The command is the 4 data-input bits sampled on the first four I/O clock rises, first bit as the MSB. A code from 0 to 13 leaves power-down on the fourth I/O clock fall, loads the channel select and, when the cycle completes, starts a conversion, so end-of-conversion goes low.
- R5: Code 1110b enters software power-down on the fourth I/O clock fall. The bias turns off, the sample window stays closed, no conversion starts and the result buffer keeps its value.
- R6: Code 1111b is reserved. It starts no conversion and leaves the power state as it was.
- R7: The sample window is closed before the fourth I/O clock fall of an accepted address. It is open from that fall until the twelfth fall, where the conversion starts.
- R8: The result is sent MSB first, 12 bits per cycle. In a cycle started by a chip-select fall, the MSB of the buffered result is on the data output as soon as the output is enabled, before the debounce has finished. Each I/O clock fall moves to the next bit.
- R9: While a conversion runs, end-of-conversion is low and the enabled data output is held low. If chip select stays low, the MSB of the new result appears when end-of-conversion rises. The next 12 I/O clocks shift out that result without any chip-select toggle.
- R10: Raising chip select for longer than the debounce interval before the twelfth I/O clock aborts the transfer. No conversion starts and the result buffer is unchanged.
- R11: A debounced new cycle that begins while a conversion runs aborts it. End-of-conversion returns high, and the buffer keeps the earlier result, which is sent in that cycle.
- R12: The bias turns off when a conversion completes (automatic power-down). It turns back on when chip select goes active, unless software power-down is in force.
- R13: The internal test flag is high when the selected channel is 11, 12 or 13 and low for the external channels 0 to 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select pin, active low, asynchronous |
| io_clk | input | 1 | Serial I/O clock pin, asynchronous |
| sdi | input | 1 | Serial command data pin |
| ana_word | input | 12 | Word from the analog comparator path, captured when a conversion ends |
| sdo | output | 1 | Serial result bit |
| sdo_oe | output | 1 | Output enable for the serial result pin |
| eoc | output | 1 | End of conversion, low while converting |
| mux_sel | output | 4 | Selected multiplexer channel |
| mux_test | output | 1 | Selected channel is an internal test voltage |
| sample_en | output | 1 | Sample window open |
| conv_start | output | 1 | One-cycle conversion start pulse |
| bias_en | output | 1 | Analog bias enable (low in either power-down) |

## Verification
The command decoder is driven with an external address, an internal test address, the power-down code and the reserved code. This separates conversion start from power-state handling and from multiplexer steering. Serial output is read in three ways: in cycles started by a chip-select fall, in back-to-back cycles with chip select held low, and after a cycle in which a conversion was aborted. A launch from chip select, a launch from end-of-conversion and a retained buffer each give a different first bit. Chip select is also disturbed in three ways: a short glitch, a raise in the middle of a transfer, and a fresh cycle during a conversion. Each one shows whether the debounce gate, the transfer abort and the conversion abort act on their own.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
   localparam int CMD_BITS = 4;
   typedef logic [CMD_BITS-1:0] cmd_t;
   localparam cmd_t CMD_SW_PD   = 4'b1110;
   localparam cmd_t CMD_RSVD    = 4'b1111;
   localparam cmd_t LAST_EXT_CH = 4'd10;
endpackage

// File: rtl/sadc_sync.sv
module sadc_sync #(
   parameter int          WIDTH   = 3,
   parameter int          STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q,
   output logic [WIDTH-1:0] rise,
   output logic [WIDTH-1:0] fall
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sadc_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];
   logic [WIDTH-1:0] prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= RST_VAL;
      else        chain[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= RST_VAL;
         else        chain[s] <= chain[s-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= RST_VAL;
      else        prev <= chain[STAGES-1];
   end

   assign q    = chain[STAGES-1];
   assign rise = q & ~prev;
   assign fall = ~q & prev;
endmodule

// File: rtl/sadc_cs_filter.sv
module sadc_cs_filter #(
   parameter int DEB_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n_s,
   output logic cs_act,
   output logic act_start,
   output logic act_end
);
   if (DEB_CYC < 1) begin : g_bad_deb
      $error("sadc_cs_filter: DEB_CYC must be at least 1");
   end

   localparam int CW = (DEB_CYC > 1) ? $clog2(DEB_CYC) : 1;
   localparam logic [CW-1:0] CNT_LAST = CW'(DEB_CYC - 1);

   logic          level;
   logic [CW-1:0] cnt;
   logic          settle;

   assign level  = ~cs_n_s;
   assign settle = (level != cs_act) && (cnt == CNT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         cs_act    <= 1'b0;
         act_start <= 1'b0;
         act_end   <= 1'b0;
      end else begin
         act_start <= settle & level;
         act_end   <= settle & ~level;
         if (level == cs_act) begin
            cnt <= '0;
         end else if (settle) begin
            cnt    <= '0;
            cs_act <= level;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assert_active_needs_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_act) |-> $past(level));
   assert_start_follows_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
      act_start |-> cs_act);
endmodule

// File: rtl/sadc_conv_stub.sv
module sadc_conv_stub #(
   parameter int RES_W    = 12,
   parameter int CONV_CYC = 48
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             abort,
   input  logic [RES_W-1:0] ana_word,
   output logic             busy,
   output logic             done,
   output logic [RES_W-1:0] result
);
   if (CONV_CYC < 2) begin : g_bad_conv
      $error("sadc_conv_stub: CONV_CYC must be at least 2");
   end

   localparam int TW = $clog2(CONV_CYC);
   localparam logic [TW-1:0] T_LAST = TW'(CONV_CYC - 1);

   logic [TW-1:0] tmr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         done   <= 1'b0;
         tmr    <= '0;
         result <= '0;
      end else begin
         done <= 1'b0;
         if (abort) begin
            busy <= 1'b0;
         end else if (start) begin
            busy <= 1'b1;
            tmr  <= '0;
         end else if (busy) begin
            if (tmr == T_LAST) begin
               busy   <= 1'b0;
               done   <= 1'b1;
               result <= ana_word;
            end else begin
               tmr <= tmr + 1'b1;
            end
         end
      end
   end

   assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy));
   assert_abort_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> !busy && !done);
endmodule

// File: rtl/sadc_ctrl.sv
module sadc_ctrl
   import sadc_pkg::*;
#(
   parameter int RES_W       = 12,
   parameter int DEB_CYC     = 4,
   parameter int CONV_CYC    = 48,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             io_clk,
   input  logic             sdi,
   input  logic [RES_W-1:0] ana_word,
   output logic             sdo,
   output logic             sdo_oe,
   output logic             eoc,
   output logic [3:0]       mux_sel,
   output logic             mux_test,
   output logic             sample_en,
   output logic             conv_start,
   output logic             bias_en
);
   if (RES_W <= CMD_BITS) begin : g_bad_res
      $error("sadc_ctrl: RES_W must exceed the command length");
   end

   localparam int CNT_W = $clog2(RES_W + 1);
   localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_BITS - 1);
   localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(RES_W - 1);
   localparam logic [CNT_W-1:0] BIT_END  = CNT_W'(RES_W);

   // pin synchronisers: {sdi, io_clk, cs_n}
   logic [2:0] pin_q, pin_rise, pin_fall;
   sadc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({sdi, io_clk, cs_n}),
      .q(pin_q), .rise(pin_rise), .fall(pin_fall));

   logic cs_n_s, sdi_s, ioc_rise, ioc_fall, cs_fall;
   assign cs_n_s   = pin_q[0];
   assign sdi_s    = pin_q[2];
   assign ioc_rise = pin_rise[1];
   assign ioc_fall = pin_fall[1];
   assign cs_fall  = pin_fall[0];

   logic cs_act, act_start, act_end;
   sadc_cs_filter #(.DEB_CYC(DEB_CYC)) u_csf (
      .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s),
      .cs_act(cs_act), .act_start(act_start), .act_end(act_end));

   logic             conv_busy, conv_done, conv_abort;
   logic [RES_W-1:0] conv_res;
   assign conv_abort = act_start & conv_busy;
   sadc_conv_stub #(.RES_W(RES_W), .CONV_CYC(CONV_CYC)) u_conv (
      .clk(clk), .rst_n(rst_n), .start(conv_start), .abort(conv_abort),
      .ana_word(ana_word), .busy(conv_busy), .done(conv_done), .result(conv_res));

   logic [CNT_W-1:0] bitcnt;
   cmd_t             cmd_sr;
   logic [RES_W-1:0] shreg, outbuf;
   logic             sw_pd, auto_sleep, conv_pend;
   logic             conv_run;

   assign conv_run = conv_busy | conv_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bitcnt     <= '0;
         cmd_sr     <= '0;
         shreg      <= '0;
         outbuf     <= '0;
         sw_pd      <= 1'b1;
         auto_sleep <= 1'b0;
         conv_pend  <= 1'b0;
         sample_en  <= 1'b0;
         conv_start <= 1'b0;
         mux_sel    <= '0;
      end else begin
         conv_start <= 1'b0;
         if (cs_fall || (cs_act && ioc_rise)) auto_sleep <= 1'b0;
         if (act_start) begin
            bitcnt    <= '0;
            cmd_sr    <= '0;
            shreg     <= outbuf;
            sample_en <= 1'b0;
            conv_pend <= 1'b0;
         end else if (act_end) begin
            sample_en <= 1'b0;
            conv_pend <= 1'b0;
         end else if (cs_act) begin
            if (ioc_rise && bitcnt <= CMD_LAST) cmd_sr <= {cmd_sr[CMD_BITS-2:0], sdi_s};
            if (ioc_fall && bitcnt < BIT_END) begin
               bitcnt <= bitcnt + 1'b1;
               shreg  <= shreg << 1;
               if (bitcnt == CMD_LAST) begin
                  if (cmd_sr == CMD_SW_PD) begin
                     sw_pd <= 1'b1;
                  end else if (cmd_sr != CMD_RSVD) begin
                     sw_pd     <= 1'b0;
                     mux_sel   <= cmd_sr;
                     sample_en <= 1'b1;
                     conv_pend <= 1'b1;
                  end
               end
               if (bitcnt == BIT_LAST) begin
                  sample_en <= 1'b0;
                  conv_pend <= 1'b0;
                  if (conv_pend) conv_start <= 1'b1;
               end
            end
         end
         if (conv_done) begin
            outbuf     <= conv_res;
            auto_sleep <= 1'b1;
            if (cs_act && !act_end) begin
               shreg  <= conv_res;
               bitcnt <= '0;
               cmd_sr <= '0;
            end
         end
      end
   end

   assign sdo_oe   = ~cs_n_s;
   assign eoc      = ~conv_run;
   assign sdo      = conv_run ? 1'b0 : (cs_act ? shreg[RES_W-1] : outbuf[RES_W-1]);
   assign mux_test = (mux_sel > LAST_EXT_CH) && (mux_sel != CMD_SW_PD) && (mux_sel != CMD_RSVD);
   assign bias_en  = ~sw_pd & ~auto_sleep;

   assert_pd_no_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sw_pd |-> !sample_en);
   assert_start_closes_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> $past(sample_en) && !sample_en);
   assert_bitcnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bitcnt <= BIT_END);
   assert_new_cycle_ends_conv_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (act_start && conv_busy) |=> eoc);
   assert_done_sleeps_R12: assert property (@(posedge clk) disable iff (!rst_n)
      conv_done |=> !bias_en);
endmodule

// File: tb/sadc_ctrl_tb_top.sv
module sadc_ctrl_tb_top;
   localparam int RES_W = 12;
   localparam int DEB   = 4;
   localparam int CONV  = 40;
   localparam int H     = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, io_clk = 1'b0, sdi = 1'b0;
   logic [RES_W-1:0] ana_word = '0;
   logic sdo, sdo_oe, eoc, mux_test, sample_en, conv_start, bias_en;
   logic [3:0] mux_sel;

   int n_chk = 0;
   int n_bad = 0;
   bit done_flag = 0;

   always #10 clk = ~clk;

   sadc_ctrl #(.RES_W(RES_W), .DEB_CYC(DEB), .CONV_CYC(CONV), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .io_clk(io_clk), .sdi(sdi),
      .ana_word(ana_word), .sdo(sdo), .sdo_oe(sdo_oe), .eoc(eoc),
      .mux_sel(mux_sel), .mux_test(mux_test), .sample_en(sample_en),
      .conv_start(conv_start), .bias_en(bias_en));

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   task automatic report();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   task automatic cs_low();
      cs_n = 1'b0;
      tick(12);
   endtask

   task automatic wait_eoc();
      for (int k = 0; k < 4 * CONV && !eoc; k++) tick(1);
      tick(3);
   endtask

   // nb I/O clocks; compares each sent bit against exp when chk_data
   task automatic xfer(input logic [3:0] cmd, input int nb, input logic [RES_W-1:0] exp,
                       input bit chk_data, input logic exp_samp, input string rq);
      for (int i = 0; i < nb; i++) begin
         if (chk_data) chk(rq, $sformatf("data bit %0d", i), 32'(sdo), 32'(exp[RES_W-1-i]));
         if (i == 3) chk("R7", "window closed before 4th fall", 32'(sample_en), 32'(0));
         sdi = (i < 4) ? cmd[3-i] : 1'b0;
         io_clk = 1'b1; tick(H);
         io_clk = 1'b0; tick(H);
         if (i == 3) chk("R7", "window after 4th fall", 32'(sample_en), 32'(exp_samp));
      end
   endtask

   task automatic t_reset_R1();
      chk("R1", "oe", 32'(sdo_oe), 0);
      chk("R1", "eoc", 32'(eoc), 1);
      chk("R1", "sample", 32'(sample_en), 0);
      chk("R1", "mux", 32'(mux_sel), 0);
      chk("R1", "bias", 32'(bias_en), 0);
   endtask

   task automatic t_first_conv_R4();
      ana_word = 12'hA5C;
      cs_low();
      chk("R2", "oe on cs low", 32'(sdo_oe), 1);
      xfer(4'd3, 12, 12'h000, 1, 1'b1, "R1");
      chk("R4", "eoc low after address", 32'(eoc), 0);
      chk("R4", "mux select", 32'(mux_sel), 3);
      chk("R13", "external channel flag", 32'(mux_test), 0);
      chk("R7", "window closed at start", 32'(sample_en), 0);
      cs_n = 1'b1; tick(4);
      chk("R2", "oe off on cs high", 32'(sdo_oe), 0);
      wait_eoc();
      chk("R4", "eoc back high", 32'(eoc), 1);
      chk("R12", "bias off after conversion", 32'(bias_en), 0);
   endtask

   task automatic t_glitch_R3();
      cs_n = 1'b0; tick(2); cs_n = 1'b1; tick(8);
      for (int i = 0; i < 12; i++) begin
         sdi = (i < 4) ? (4'd6 >> (3 - i)) & 1'b1 : 1'b0;
         io_clk = 1'b1; tick(H); io_clk = 1'b0; tick(H);
      end
      tick(4);
      chk("R3", "no conversion", 32'(eoc), 1);
      chk("R3", "mux unchanged", 32'(mux_sel), 3);
      chk("R3", "window closed", 32'(sample_en), 0);
   endtask

   task automatic t_cs_launch_R8();
      ana_word = 12'h3C9;
      cs_n = 1'b0; tick(4);
      chk("R8", "oe before debounce", 32'(sdo_oe), 1);
      chk("R8", "MSB on cs fall", 32'(sdo), 1);
      chk("R12", "bias back on cs active", 32'(bias_en), 1);
      tick(8);
      xfer(4'd12, 12, 12'hA5C, 1, 1'b1, "R8");
      chk("R13", "test channel flag", 32'(mux_test), 1);
      chk("R13", "test channel select", 32'(mux_sel), 12);
      cs_n = 1'b1;
      wait_eoc();
   endtask

   task automatic t_swpd_R5();
      cs_low();
      xfer(4'b1110, 12, 12'h3C9, 1, 1'b0, "R5");
      chk("R5", "bias off in power-down", 32'(bias_en), 0);
      tick(10);
      chk("R5", "no conversion", 32'(eoc), 1);
      cs_n = 1'b1; tick(10);
   endtask

   task automatic t_rsvd_R6();
      cs_low();
      xfer(4'b1111, 12, 12'h3C9, 1, 1'b0, "R6");
      tick(10);
      chk("R6", "no conversion", 32'(eoc), 1);
      chk("R6", "still powered down", 32'(bias_en), 0);
      cs_n = 1'b1; tick(10);
   endtask

   task automatic t_held_R9();
      ana_word = 12'hB17;
      cs_low();
      xfer(4'd5, 12, 12'h3C9, 1, 1'b1, "R9");
      tick(2);
      chk("R9", "eoc low while converting", 32'(eoc), 0);
      chk("R9", "data forced low", 32'(sdo), 0);
      wait_eoc();
      chk("R9", "MSB on eoc rise", 32'(sdo), 1);
      ana_word = 12'h2F0;
      xfer(4'd5, 12, 12'hB17, 1, 1'b1, "R9");
      wait_eoc();
      cs_n = 1'b1; tick(10);
   endtask

   task automatic t_abort_xfer_R10();
      cs_low();
      xfer(4'd7, 6, 12'h2F0, 1, 1'b1, "R10");
      cs_n = 1'b1; tick(20);
      chk("R10", "window closed", 32'(sample_en), 0);
      chk("R10", "no conversion", 32'(eoc), 1);
      tick(CONV);
      chk("R10", "still no conversion", 32'(eoc), 1);
   endtask

   task automatic t_abort_conv_R11();
      ana_word = 12'h155;
      cs_low();
      xfer(4'd9, 12, 12'h2F0, 1, 1'b1, "R10");
      chk("R11", "converting", 32'(eoc), 0);
      cs_n = 1'b1; tick(10);
      cs_n = 1'b0; tick(12);
      chk("R11", "eoc high after abort", 32'(eoc), 1);
      ana_word = 12'h800;
      xfer(4'd10, 12, 12'h2F0, 1, 1'b1, "R11");
      cs_n = 1'b1;
      wait_eoc();
      cs_low();
      xfer(4'b1110, 12, 12'h800, 1, 1'b0, "R11");
      cs_n = 1'b1; tick(10);
   endtask

   initial begin
      tick(3);
      t_reset_R1();
      rst_n = 1'b1;
      tick(3);
      t_first_conv_R4();
      t_glitch_R3();
      t_cs_launch_R8();
      t_swpd_R5();
      t_rsvd_R6();
      t_held_R9();
      t_abort_xfer_R10();
      t_abort_conv_R11();
      done_flag = 1;
      report();
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done_flag) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         report();
      end
   end
endmodule